// File: doc/BRIEF.md
# Subroutine Frame Sequencer with Run-Time Frame Size

This block moves subroutine return frames between a small 4-bit processor core and its nibble-wide data RAM. The core raises a call request with the current 14-bit program counter and two status flags, and the sequencer writes the frame into the RAM one nibble per cycle, walking the 8-bit stack pointer downward. A return request reads the frame back, walking the pointer upward, and then presents the restored program counter for one cycle.

A 4-bit select register sets two things: the frame format and the stack page. In the compact format a frame holds the 14-bit counter in four nibbles. In the extended format two more nibbles carry the status flags and padding. The select register also picks which 256-nibble page of RAM holds the stack, and it flags a forbidden page code. The sequencer reports the machine-cycle cost of each accepted call. It also rejects the long call and long branch forms when the compact format is active.

The RAM interface has one synchronous write port and an asynchronous read port. Both share a 9-bit address formed as page bit above stack pointer.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, sel_q is 4'b1000 (compact format, page 0), sp_out is 00h, and busy, illegal, ovf, pc_valid and call_cycles are all 0.
- R2: When busy is low, sel_we loads sel_q with sel_wdata, except that bit 2 is stored as 0. Bit 3 = 1 selects the compact format and bit 3 = 0 selects the extended format. Bit 0 is the stack page.
- R3: bank_err equals sel_q[1]. While it is 1, neither a call request nor a return request is accepted.
- R4: A compact-format call writes four nibbles of {2'b00, pc_in}, most significant nibble first. Each write goes to address {page, SP-1}, and SP is decremented after every write. SP therefore ends 4 lower.
- R5: An extended-format call first writes nibble 0h and then {2'b00, flags_in}, each at {page, SP-1} with SP decremented after the write. It then writes the four counter nibbles as in R4. SP ends 6 lower.
- R6: A return reads 4 nibbles (compact) or 6 nibbles (extended) from {page, SP}, incrementing SP after each read. The first nibble read is the least significant. In the cycle after the last read, pc_valid is high for exactly one cycle, and pc_out holds the restored counter. In the extended format, flags_out holds bits 1:0 of the fifth nibble read.
- R7: For each accepted call, call_cycles takes the call's cost. With call_kind 00 (absolute) the cost is 3 in compact and 4 in extended. With 01 (fast) it is 2 in compact and 3 in extended. With 1x (long) it is 4.
- R8: In the compact format, a long call (call_kind 1x) is not accepted and pulses illegal in the next cycle. A br_long pulse does the same. In the extended format, neither one raises illegal.
- R9: busy goes high in the cycle after a request is accepted. It stays high for exactly one cycle per nibble, with one RAM transfer per cycle. Requests, sel_we and sp_we that arrive while busy is high are ignored.
- R10: ovf is set when the stack pointer wraps, either from 00h to FFh or from FFh to 00h. It stays set until reset.
- R11: If call_req and ret_req are both high, the call takes precedence and the return is dropped. A request accepted in the same cycle as a select write uses the format and page that were in effect before that write.
- R12: When busy is low, sp_we loads sp_out with sp_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 4 | New select register value |
| sp_we | input | 1 | Stack pointer load strobe |
| sp_wdata | input | 8 | Stack pointer load value |
| call_req | input | 1 | Call request |
| call_kind | input | 2 | 00 absolute, 01 fast, 1x long |
| ret_req | input | 1 | Return request |
| br_long | input | 1 | Long branch form issued (legality check only) |
| pc_in | input | 14 | Program counter to save |
| flags_in | input | 2 | Status flags to save in the extended format |
| mem_rdata | input | 4 | RAM read data (combinational from mem_addr) |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read strobe |
| mem_addr | output | 9 | RAM nibble address {page, pointer} |
| mem_wdata | output | 4 | RAM write data |
| busy | output | 1 | Frame transfer in progress |
| sel_q | output | 4 | Select register contents |
| sp_out | output | 8 | Stack pointer |
| bank_err | output | 1 | Forbidden page code in the select register |
| illegal | output | 1 | Long form rejected in the compact format |
| ovf | output | 1 | Sticky stack pointer wrap flag |
| call_cycles | output | 3 | Machine-cycle cost of the last accepted call |
| pc_valid | output | 1 | One-cycle strobe for a restored counter |
| pc_out | output | 14 | Restored program counter |
| flags_out | output | 2 | Restored status flags |

## Verification
Several actions can fall on the same clock edge while the sequencer is idle: a call request, a return request and a select-register write. The bench raises call_req and ret_req together in one idle cycle and expects only the push to start. In a later idle cycle it pairs a call with a select write that switches from the extended to the compact format. There it expects six nibble writes, not four, while sel_q already shows the new value. A behavioural reference model, built on queues of pending transfers, predicts every RAM strobe, address and data nibble in every cycle, so any wrong precedence shows up as a per-cycle mismatch.

// File: rtl/stack_frame_seq.sv
module stack_frame_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_we,
  input  logic [3:0]  sel_wdata,
  input  logic        sp_we,
  input  logic [7:0]  sp_wdata,
  input  logic        call_req,
  input  logic [1:0]  call_kind,
  input  logic        ret_req,
  input  logic        br_long,
  input  logic [13:0] pc_in,
  input  logic [1:0]  flags_in,
  input  logic [3:0]  mem_rdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic [8:0]  mem_addr,
  output logic [3:0]  mem_wdata,
  output logic        busy,
  output logic [3:0]  sel_q,
  output logic [7:0]  sp_out,
  output logic        bank_err,
  output logic        illegal,
  output logic        ovf,
  output logic [2:0]  call_cycles,
  output logic        pc_valid,
  output logic [13:0] pc_out,
  output logic [1:0]  flags_out
);

  logic [2:0]  cnt;
  logic        push_q, ext_q, bank_q;
  logic [23:0] frame, rd_asm;
  logic [2:0]  wr_nib, rd_nib, cyc;
  logic        call_ok, ret_ok;

  assign busy      = (cnt != 3'd0);
  assign bank_err  = sel_q[1];
  assign mem_we    = busy & push_q;
  assign mem_re    = busy & ~push_q;
  assign mem_addr  = {bank_q, push_q ? sp_out - 8'd1 : sp_out};
  assign wr_nib    = cnt - 3'd1;
  assign rd_nib    = (ext_q ? 3'd6 : 3'd4) - cnt;
  assign mem_wdata = frame[{wr_nib, 2'b00} +: 4];

  assign call_ok = ~busy & ~sel_q[1] & call_req & ~(call_kind[1] & sel_q[3]);
  assign ret_ok  = ~busy & ~sel_q[1] & ~call_req & ret_req;
  assign cyc = call_kind[1] ? 3'd4 :
               call_kind[0] ? (sel_q[3] ? 3'd2 : 3'd3) : (sel_q[3] ? 3'd3 : 3'd4);

  always_comb begin
    rd_asm = frame;
    rd_asm[{rd_nib, 2'b00} +: 4] = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 4'b1000;
      sp_out <= 8'h00;
      cnt <= 3'd0;
      push_q <= 1'b0;
      ext_q <= 1'b0;
      bank_q <= 1'b0;
      frame <= '0;
      illegal <= 1'b0;
      ovf <= 1'b0;
      call_cycles <= 3'd0;
      pc_valid <= 1'b0;
      pc_out <= '0;
      flags_out <= 2'b00;
    end else begin
      illegal  <= sel_q[3] & (br_long | (call_req & call_kind[1] & ~busy));
      pc_valid <= 1'b0;
      if (busy) begin
        cnt <= cnt - 3'd1;
        if (push_q) begin
          sp_out <= sp_out - 8'd1;
          if (sp_out == 8'h00) ovf <= 1'b1;
        end else begin
          sp_out <= sp_out + 8'd1;
          if (sp_out == 8'hFF) ovf <= 1'b1;
          frame <= rd_asm;
          if (cnt == 3'd1) begin
            pc_valid <= 1'b1;
            pc_out <= rd_asm[13:0];
            if (ext_q) flags_out <= rd_asm[17:16];
          end
        end
      end else begin
        if (sel_we) sel_q <= {sel_wdata[3], sel_wdata[2] & 1'b0, sel_wdata[1:0]};
        if (sp_we) sp_out <= sp_wdata;
        if (call_ok) begin
          push_q <= 1'b1;
          ext_q <= ~sel_q[3];
          bank_q <= sel_q[0];
          cnt <= sel_q[3] ? 3'd4 : 3'd6;
          frame <= {6'b0, flags_in, 2'b00, pc_in};
          call_cycles <= cyc;
        end else if (ret_ok) begin
          push_q <= 1'b0;
          ext_q <= ~sel_q[3];
          bank_q <= sel_q[0];
          cnt <= sel_q[3] ? 3'd4 : 3'd6;
        end
      end
    end
  end

  assert_sel_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && !busy) |=> (sel_q == {$past(sel_wdata[3]), 1'b0, $past(sel_wdata[1:0])}));

  assert_bank_err_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_err && !busy) |=> !busy);

  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) - 8'd1));

  assert_pop_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp_out == $past(sp_out) + 8'd1));

  assert_ret_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> !busy);

  assert_illegal_compact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(sel_q[3]));

  assert_busy_freezes_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_q));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

endmodule

// File: tb/stack_frame_seq_bench.sv
module stack_frame_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 0, sp_we = 0, call_req = 0, ret_req = 0, br_long = 0;
  logic [3:0] sel_wdata = 0;
  logic [7:0] sp_wdata = 0;
  logic [1:0] call_kind = 0, flags_in = 0;
  logic [13:0] pc_in = 0;
  logic [3:0] mem_rdata;
  logic mem_we, mem_re, busy, bank_err, illegal, ovf, pc_valid;
  logic [8:0] mem_addr;
  logic [3:0] mem_wdata, sel_q;
  logic [7:0] sp_out;
  logic [2:0] call_cycles;
  logic [13:0] pc_out;
  logic [1:0] flags_out;

  always #4 clk = ~clk;

  stack_frame_seq u_stack_frame_seq (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .call_req(call_req), .call_kind(call_kind),
    .ret_req(ret_req), .br_long(br_long), .pc_in(pc_in), .flags_in(flags_in),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .sel_q(sel_q), .sp_out(sp_out),
    .bank_err(bank_err), .illegal(illegal), .ovf(ovf), .call_cycles(call_cycles),
    .pc_valid(pc_valid), .pc_out(pc_out), .flags_out(flags_out));

  logic [3:0] ram [512];
  initial for (int i = 0; i < 512; i++) ram[i] = 4'h0;
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
  assign mem_rdata = ram[mem_addr];

  int checks = 0, errs = 0, cycles = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model
  int mq_we[$];
  int mq_dat[$];
  int nibs[$];
  bit [3:0] m_sel;
  bit [3:0] m_ram [512];
  int m_sp, m_pc, m_fl, m_cyc, m_bank;
  bit m_ovf, m_ill, m_pcv;

  initial for (int i = 0; i < 512; i++) m_ram[i] = 4'h0;

  always @(posedge clk) begin
    int w, d, a;
    bit [3:0] old;
    if (!rst_n) begin
      m_sel = 4'b1000; m_sp = 0; m_pc = 0; m_fl = 0; m_cyc = 0; m_bank = 0;
      m_ovf = 0; m_ill = 0; m_pcv = 0;
      mq_we.delete(); mq_dat.delete(); nibs.delete();
    end else begin
      m_ill = m_sel[3] && (br_long || (call_req && call_kind[1] && mq_we.size() == 0));
      m_pcv = 0;
      if (mq_we.size() != 0) begin
        w = mq_we.pop_front();
        d = mq_dat.pop_front();
        if (w != 0) begin
          a = m_bank * 256 + (m_sp + 255) % 256;
          m_ram[a] = d[3:0];
          if (m_sp == 0) m_ovf = 1;
          m_sp = (m_sp + 255) % 256;
        end else begin
          a = m_bank * 256 + m_sp;
          nibs.push_back(int'(m_ram[a]));
          if (m_sp == 255) m_ovf = 1;
          m_sp = (m_sp + 1) % 256;
          if (mq_we.size() == 0) begin
            m_pc = nibs[0] + nibs[1] * 16 + nibs[2] * 256 + (nibs[3] % 4) * 4096;
            if (nibs.size() == 6) m_fl = nibs[4] % 4;
            m_pcv = 1;
            nibs.delete();
          end
        end
      end else begin
        old = m_sel;
        if (sel_we) m_sel = sel_wdata & 4'hB;
        if (sp_we) m_sp = int'(sp_wdata);
        if (!old[1]) begin
          if (call_req) begin
            if (!(call_kind[1] && old[3])) begin
              m_bank = old[0];
              if (!old[3]) begin
                mq_we.push_back(1); mq_dat.push_back(0);
                mq_we.push_back(1); mq_dat.push_back(int'(flags_in));
              end
              mq_we.push_back(1); mq_dat.push_back(int'(pc_in[13:12]));
              mq_we.push_back(1); mq_dat.push_back(int'(pc_in[11:8]));
              mq_we.push_back(1); mq_dat.push_back(int'(pc_in[7:4]));
              mq_we.push_back(1); mq_dat.push_back(int'(pc_in[3:0]));
              if (call_kind[1]) m_cyc = 4;
              else if (call_kind[0]) m_cyc = old[3] ? 2 : 3;
              else m_cyc = old[3] ? 3 : 4;
            end
          end else if (ret_req) begin
            m_bank = old[0];
            for (int k = 0; k < (old[3] ? 4 : 6); k++) begin
              mq_we.push_back(0); mq_dat.push_back(0);
            end
          end
        end
      end
    end
  end

  bit run = 0;
  int last_pc = -1, last_fl = -1;
  always @(negedge clk) if (rst_n && run) begin
    bit bz;
    bz = mq_we.size() != 0;
    chk("R9", "busy", busy, bz);
    chk("R4", "mem_we", mem_we, bz && mq_we[0] != 0);
    chk("R6", "mem_re", mem_re, bz && mq_we[0] == 0);
    if (bz) begin
      if (mq_we[0] != 0) begin
        chk("R4", "mem_addr", mem_addr, m_bank * 256 + (m_sp + 255) % 256);
        chk("R5", "mem_wdata", mem_wdata, mq_dat[0]);
      end else
        chk("R6", "mem_addr", mem_addr, m_bank * 256 + m_sp);
    end
    chk("R12", "sp_out", sp_out, m_sp);
    chk("R2", "sel_q", sel_q, m_sel);
    chk("R3", "bank_err", bank_err, m_sel[1]);
    chk("R10", "ovf", ovf, m_ovf);
    chk("R8", "illegal", illegal, m_ill);
    chk("R7", "call_cycles", call_cycles, m_cyc);
    chk("R6", "pc_valid", pc_valid, m_pcv);
    if (m_pcv) begin
      chk("R6", "pc_out", pc_out, m_pc);
      chk("R5", "flags_out", flags_out, m_fl);
      last_pc = int'(pc_out);
      last_fl = int'(flags_out);
    end
  end

  task automatic idle_wait();
    while (mq_we.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic set_sp(input [7:0] v);
    sp_we = 1; sp_wdata = v; @(negedge clk); sp_we = 0;
  endtask
  task automatic set_sel(input [3:0] v);
    sel_we = 1; sel_wdata = v; @(negedge clk); sel_we = 0;
  endtask
  task automatic do_call(input [1:0] k, input [13:0] pc, input [1:0] fl);
    call_req = 1; call_kind = k; pc_in = pc; flags_in = fl; @(negedge clk); call_req = 0;
  endtask
  task automatic do_ret();
    ret_req = 1; @(negedge clk); ret_req = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "sel_q", sel_q, 8);
    chk("R1", "sp_out", sp_out, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "ovf", ovf, 0);
    chk("R1", "illegal", illegal, 0);
    chk("R1", "pc_valid", pc_valid, 0);
    chk("R1", "call_cycles", call_cycles, 0);
    run = 1;

    // compact absolute call and return
    set_sp(8'h40);
    do_call(2'b00, 14'h3ABC, 2'b11); idle_wait();
    do_ret(); idle_wait();
    chk("R6", "compact return pc", last_pc, 14'h3ABC);
    // fast call, then long forms rejected in compact (R8)
    do_call(2'b01, 14'h07F5, 2'b00); idle_wait();
    do_call(2'b10, 14'h1000, 2'b00); @(negedge clk);
    br_long = 1; @(negedge clk); br_long = 0; @(negedge clk);
    do_ret(); idle_wait();

    // R3 forbidden page code: bit2 written as 1 also stored as 0
    set_sel(4'h7);
    do_call(2'b00, 14'h0123, 2'b00);
    chk("R3", "busy after blocked call", busy, 0);
    do_ret();
    chk("R3", "busy after blocked ret", busy, 0);

    // extended format on page 1 (R5)
    set_sel(4'h5);
    set_sp(8'h20);
    do_call(2'b10, 14'h1234, 2'b10); idle_wait();
    do_call(2'b01, 14'h0456, 2'b01); idle_wait();
    br_long = 1; @(negedge clk); br_long = 0; @(negedge clk);
    do_ret(); idle_wait();
    chk("R5", "flags restored", last_fl, 1);
    do_ret(); idle_wait();
    chk("R5", "flags restored outer", last_fl, 2);
    chk("R6", "pc restored outer", last_pc, 14'h1234);

    // R9 requests while busy are ignored
    do_call(2'b00, 14'h2222, 2'b01);
    do_call(2'b00, 14'h3333, 2'b00);
    do_ret();
    set_sel(4'h8);
    set_sp(8'h77);
    idle_wait();
    do_ret(); idle_wait();
    chk("R9", "pc after ignored requests", last_pc, 14'h2222);

    // R11 call and return together: call wins
    call_req = 1; ret_req = 1; call_kind = 2'b00; pc_in = 14'h1111; flags_in = 2'b11;
    @(negedge clk); call_req = 0; ret_req = 0;
    chk("R11", "push started", mem_we, 1);
    idle_wait();
    do_ret(); idle_wait();
    chk("R11", "pc after simultaneous", last_pc, 14'h1111);

    // R11 select write in the accept cycle: old format used
    call_req = 1; call_kind = 2'b00; pc_in = 14'h2A5A; flags_in = 2'b10;
    sel_we = 1; sel_wdata = 4'h8;
    @(negedge clk); call_req = 0; sel_we = 0;
    chk("R11", "sel_q updated", sel_q, 8);
    idle_wait();
    set_sel(4'h1);
    do_ret(); idle_wait();
    chk("R11", "pc after sel race", last_pc, 14'h2A5A);

    // R10 wrap and sticky overflow
    set_sp(8'h02);
    do_call(2'b00, 14'h0F0F, 2'b01); idle_wait();
    chk("R10", "ovf set", ovf, 1);
    do_ret(); idle_wait();
    chk("R10", "ovf held", ovf, 1);

    // nested compact calls on page 0
    set_sel(4'h8);
    set_sp(8'h80);
    do_call(2'b00, 14'h0001, 2'b00); idle_wait();
    do_call(2'b01, 14'h3FFF, 2'b00); idle_wait();
    do_call(2'b00, 14'h2000, 2'b00); idle_wait();
    do_ret(); idle_wait();
    chk("R6", "nested pc 3", last_pc, 14'h2000);
    do_ret(); idle_wait();
    chk("R6", "nested pc 2", last_pc, 14'h3FFF);
    do_ret(); idle_wait();
    chk("R6", "nested pc 1", last_pc, 14'h0001);
    chk("R12", "sp back", sp_out, 8'h80);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule